// File: doc/BRIEF.md
# Paletted Text-Mode Display Store

This block is a memory-mapped bus slave that fills a 4 KB window. It holds a grid of 16-bit character cells and a small palette of 24-bit colours. The host addresses it one 32-bit word at a time, with byte enables. Each cell word carries a 7-bit character code, a bold flag and two 4-bit palette indices. The palette is packed as three consecutive bytes per entry. A write to one control word lets software wait for the frame boundary: the bus is held off until the display timing reports a vertical sync.

On its display-side port, the block takes a column and a row from an external video timing generator. Two clock cycles later it returns the character code, the bold flag, and the foreground and background colours resolved through the palette. Each sync pulse is passed on as a one-cycle interrupt request, which the interrupt controller routes as source 15.

The grid size is set by parameters and defaults to 80 columns by 25 rows. The palette region and the control word follow directly after the cell region.

Top module: `fbt_text_top`

## Requirements
- R1: After reset, every cell and palette byte reads as zero, `bus_ready` is high with no request, and `vsync_irq` is low.
- R2: The word at byte offset 4*`bus_word`, for offsets below 0xFA0, holds cell 2*`bus_word` in bits 15:0 and cell 2*`bus_word`+1 in bits 31:16. `bus_be` bit i enables write byte i. Reads never wait.
- R3: Byte offsets 0xFA0 to 0xFCF hold the palette. Entry k uses offset 0xFA0+3k for red, 0xFA0+3k+1 for green and 0xFA0+3k+2 for blue. Byte enables apply here as in R2.
- R4: A read at any word offset from 0xFD0 upward returns zero. A write to any word above 0xFD0 changes no cell and no palette byte.
- R5: A write to word offset 0xFD0 keeps `bus_ready` low in every cycle until a cycle in which `vsync_in` is high. It completes in that cycle.
- R6: `vsync_irq` is high for exactly the cycle that follows each cycle in which `vsync_in` is high.
- R7: Suppose `disp_col`/`disp_row` are sampled at clock edge n. After edge n+2, `disp_glyph` shows bits 6:0 and `disp_bold` shows bit 7 of cell row*COLS+col.
- R8: Under the same timing, `disp_fg` shows the palette entry selected by cell bits 11:8, and `disp_bg` shows the entry selected by bits 15:12. Each colour is packed as {blue, green, red}, with red in bits 7:0.
- R9: A column of at least COLS or a row of at least ROWS is treated as a zero cell: glyph 0, bold 0, and both colours taken from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 10 | Word offset in the window (byte offset / 4) |
| bus_wdata | input | 32 | Write data, little-endian bytes |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Read data, valid while a read is requested |
| bus_ready | output | 1 | Access completes on a clock edge where valid and ready are both high |
| vsync_in | input | 1 | Vertical sync pulse from the display timing |
| vsync_irq | output | 1 | One-cycle interrupt request per sync pulse |
| disp_col | input | 7 | Display column |
| disp_row | input | 5 | Display row |
| disp_glyph | output | 7 | Character code of the looked-up cell |
| disp_bold | output | 1 | Bold flag of the looked-up cell |
| disp_fg | output | 24 | Foreground colour {B,G,R} |
| disp_bg | output | 24 | Background colour {B,G,R} |

## Verification
The assertions assume that a bus master keeps `bus_valid`, `bus_write` and `bus_word` stable until the access completes. This matters most while a sync wait is stalled. They also assume that no display lookup is being checked while the palette is being rewritten. The stimulus drives each access from the falling edge, holds it through every stalled cycle, and releases it only after the completing rising edge. Random writes avoid the control word, which is exercised only by directed cases. Display lookups are made only while the bus is idle.

// File: rtl/fbt_pkg.sv
`timescale 1ns/1ps
package fbt_pkg;
    localparam int WORD_W      = 10;
    localparam int DATA_W      = 32;
    localparam int PAL_ENTRIES = 16;
    localparam int PAL_BYTES   = PAL_ENTRIES * 3;
    localparam int PAL_AW      = $clog2(PAL_BYTES);
    localparam int RGB_W       = 24;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CELL = 2'd1,
        RGN_PAL  = 2'd2,
        RGN_SYNC = 2'd3
    } fbt_region_e;

    typedef struct packed {
        logic [6:0]       glyph;
        logic             bold;
        logic [RGB_W-1:0] fg;
        logic [RGB_W-1:0] bg;
    } fbt_pixel_t;
endpackage

// File: rtl/fbt_decode.sv
`timescale 1ns/1ps
module fbt_decode
    import fbt_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 25
) (
    input  logic [WORD_W-1:0]          word,
    output fbt_region_e                region,
    output logic [$clog2(COLS*ROWS)-1:0] cell_base,
    output logic [PAL_AW-1:0]          pal_off
);
    localparam int NCELL      = COLS * ROWS;
    localparam int CELL_AW    = $clog2(NCELL);
    localparam int CELL_WORDS = NCELL / 2;
    localparam int PAL_WORD0  = CELL_WORDS;
    localparam int PAL_WORDS  = PAL_BYTES / 4;
    localparam int SYNC_WORD  = PAL_WORD0 + PAL_WORDS;

    always_comb begin
        region    = RGN_NONE;
        cell_base = CELL_AW'(int'(word) * 2);
        pal_off   = PAL_AW'((int'(word) - PAL_WORD0) * 4);
        if (int'(word) < CELL_WORDS) begin
            region = RGN_CELL;
        end else if (int'(word) < SYNC_WORD) begin
            region = RGN_PAL;
        end else if (int'(word) == SYNC_WORD) begin
            region = RGN_SYNC;
        end
    end
endmodule

// File: rtl/fbt_cell_store.sv
`timescale 1ns/1ps
module fbt_cell_store
    import fbt_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 25
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(COLS*ROWS)-1:0] base,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [3:0]                   wr_be,
    output logic [DATA_W-1:0]            rd_data,
    input  logic [$clog2(COLS)-1:0]      disp_col,
    input  logic [$clog2(ROWS)-1:0]      disp_row,
    output logic [15:0]                  cell_q
);
    localparam int NCELL   = COLS * ROWS;
    localparam int CELL_AW = $clog2(NCELL);

    logic [15:0]        cells [NCELL];
    logic [15:0]        cell_d;
    logic               offscreen;
    logic [CELL_AW-1:0] disp_idx;

    // bus write: two cells per word, one enable per byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCELL; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            for (int h = 0; h < 2; h++) begin
                for (int b = 0; b < 2; b++) begin
                    if (wr_be[2*h+b]) begin
                        cells[CELL_AW'(int'(base) + h)][8*b +: 8] <= wr_data[16*h + 8*b +: 8];
                    end
                end
            end
        end
    end

    always_comb begin
        rd_data = {cells[CELL_AW'(int'(base) + 1)], cells[base]};
    end

    // display stage 1: cell fetch
    always_comb begin
        offscreen = (int'(disp_col) >= COLS) || (int'(disp_row) >= ROWS);
        disp_idx  = CELL_AW'(int'(disp_row) * COLS + int'(disp_col));
        cell_d    = offscreen ? 16'h0000 : cells[disp_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    AST_OFFSCREEN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(offscreen) |-> (cell_q == 16'h0000)); // R9
endmodule

// File: rtl/fbt_palette.sv
`timescale 1ns/1ps
module fbt_palette
    import fbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAL_AW-1:0] off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        wr_be,
    output logic [DATA_W-1:0] rd_data,
    input  logic [3:0]        fg_idx,
    input  logic [3:0]        bg_idx,
    output logic [RGB_W-1:0]  fg_rgb,
    output logic [RGB_W-1:0]  bg_rgb
);
    logic [7:0] pal [PAL_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAL_BYTES; i++) begin
                pal[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < 4; i++) begin
                if (wr_be[i] && (int'(off) + i < PAL_BYTES)) begin
                    pal[PAL_AW'(int'(off) + i)] <= wr_data[8*i +: 8];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < 4; i++) begin
            if (int'(off) + i < PAL_BYTES) begin
                rd_data[8*i +: 8] = pal[PAL_AW'(int'(off) + i)];
            end
        end
    end

    // colour resolve: three bytes per entry, red lowest
    always_comb begin
        fg_rgb = {pal[PAL_AW'(3*int'(fg_idx) + 2)],
                  pal[PAL_AW'(3*int'(fg_idx) + 1)],
                  pal[PAL_AW'(3*int'(fg_idx))]};
        bg_rgb = {pal[PAL_AW'(3*int'(bg_idx) + 2)],
                  pal[PAL_AW'(3*int'(bg_idx) + 1)],
                  pal[PAL_AW'(3*int'(bg_idx))]};
    end
endmodule

// File: rtl/fbt_text_top.sv
`timescale 1ns/1ps
module fbt_text_top
    import fbt_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [WORD_W-1:0]       bus_word,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic [3:0]              bus_be,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_ready,
    input  logic                    vsync_in,
    output logic                    vsync_irq,
    input  logic [$clog2(COLS)-1:0] disp_col,
    input  logic [$clog2(ROWS)-1:0] disp_row,
    output logic [6:0]              disp_glyph,
    output logic                    disp_bold,
    output logic [RGB_W-1:0]        disp_fg,
    output logic [RGB_W-1:0]        disp_bg
);
    localparam int NCELL   = COLS * ROWS;
    localparam int CELL_AW = $clog2(NCELL);

    typedef struct packed {
        logic       stall;
        logic       irq;
        fbt_pixel_t pix;
    } fbt_state_t;

    fbt_state_t         st_d, st_q;
    fbt_region_e        region;
    logic [CELL_AW-1:0] cell_base;
    logic [PAL_AW-1:0]  pal_off;
    logic [DATA_W-1:0]  cell_rd, pal_rd;
    logic [15:0]        cell_q;
    logic [RGB_W-1:0]   fg_rgb, bg_rgb;
    logic               wr_cell, wr_pal, sync_req;

    fbt_decode #(.COLS(COLS), .ROWS(ROWS)) i_decode (
        .word      (bus_word),
        .region    (region),
        .cell_base (cell_base),
        .pal_off   (pal_off)
    );

    fbt_cell_store #(.COLS(COLS), .ROWS(ROWS)) i_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cell),
        .base     (cell_base),
        .wr_data  (bus_wdata),
        .wr_be    (bus_be),
        .rd_data  (cell_rd),
        .disp_col (disp_col),
        .disp_row (disp_row),
        .cell_q   (cell_q)
    );

    fbt_palette i_palette (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_pal),
        .off     (pal_off),
        .wr_data (bus_wdata),
        .wr_be   (bus_be),
        .rd_data (pal_rd),
        .fg_idx  (cell_q[11:8]),
        .bg_idx  (cell_q[15:12]),
        .fg_rgb  (fg_rgb),
        .bg_rgb  (bg_rgb)
    );

    // bus side
    always_comb begin
        sync_req  = bus_valid && bus_write && (region == RGN_SYNC);
        bus_ready = !sync_req || vsync_in;
        wr_cell   = bus_valid && bus_write && (region == RGN_CELL);
        wr_pal    = bus_valid && bus_write && (region == RGN_PAL);
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (region)
                RGN_CELL: bus_rdata = cell_rd;
                RGN_PAL:  bus_rdata = pal_rd;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // next state: stall marker, interrupt pulse, display stage 2
    always_comb begin
        st_d           = st_q;
        st_d.stall     = sync_req && !vsync_in;
        st_d.irq       = vsync_in;
        st_d.pix.glyph = cell_q[6:0];
        st_d.pix.bold  = cell_q[7];
        st_d.pix.fg    = fg_rgb;
        st_d.pix.bg    = bg_rgb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vsync_irq  = st_q.irq;
    assign disp_glyph = st_q.pix.glyph;
    assign disp_bold  = st_q.pix.bold;
    assign disp_fg    = st_q.pix.fg;
    assign disp_bg    = st_q.pix.bg;

    AST_SYNC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stall && bus_valid && bus_write && !vsync_in) |-> !bus_ready); // R5
    AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stall && bus_valid && bus_ready) |-> vsync_in); // R5
    AST_READ_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |-> bus_ready); // R2
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |-> $past(vsync_in)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (region == RGN_NONE || region == RGN_SYNC)) |-> (bus_rdata == '0)); // R4
endmodule

// File: tb/test_fbt_text_top.sv
`timescale 1ns/1ps
module test_fbt_text_top;
    localparam int COLS = 80;
    localparam int ROWS = 25;
    localparam int NCELL = COLS * ROWS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [9:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        vsync_in = 1'b0;
    logic        vsync_irq;
    logic [6:0]  disp_col = '0;
    logic [4:0]  disp_row = '0;
    logic [6:0]  disp_glyph;
    logic        disp_bold;
    logic [23:0] disp_fg, disp_bg;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_cell [NCELL];
    logic [7:0]  m_pal [48];

    always #10 clk = ~clk;

    fbt_text_top #(.COLS(COLS), .ROWS(ROWS)) i_fbt_text_top (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .vsync_in(vsync_in),
        .vsync_irq(vsync_irq), .disp_col(disp_col), .disp_row(disp_row),
        .disp_glyph(disp_glyph), .disp_bold(disp_bold), .disp_fg(disp_fg), .disp_bg(disp_bg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r = '0;
        if (w < NCELL / 2) begin
            r = {m_cell[2*w+1], m_cell[2*w]};
        end else if (w < NCELL / 2 + 12) begin
            for (int i = 0; i < 4; i++) r[8*i +: 8] = m_pal[(w - NCELL/2)*4 + i];
        end
        return r;
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [3:0] k);
        return {m_pal[3*k+2], m_pal[3*k+1], m_pal[3*k]};
    endfunction

    task automatic model_write(input int w, input logic [31:0] d, input logic [3:0] be);
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                if (w < NCELL / 2) m_cell[2*w + i/2][8*(i%2) +: 8] = d[8*i +: 8];
                else if (w < NCELL / 2 + 12) m_pal[(w - NCELL/2)*4 + i] = d[8*i +: 8];
            end
        end
    endtask

    task automatic bus_wr(input int w, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = 10'(w); bus_wdata = d; bus_be = be;
        #2;
        while (!bus_ready) begin @(negedge clk); #2; end
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
        model_write(w, d, be);
    endtask

    task automatic bus_rd(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_word = 10'(w);
        #2;
        d = bus_rdata;
        @(posedge clk);
        #1 bus_valid = 1'b0;
    endtask

    task automatic disp_chk(input int col, input int row);
        logic [15:0] c;
        @(negedge clk);
        disp_col = 7'(col); disp_row = 5'(row);
        @(negedge clk);
        @(negedge clk);
        c = (col < COLS && row < ROWS) ? m_cell[row*COLS + col] : 16'h0;
        if (c == 16'h0 && !(col < COLS && row < ROWS)) begin
            chk("R9 offscreen glyph", {25'h0, disp_glyph}, 32'h0);
            chk("R9 offscreen fg", {8'h0, disp_fg}, {8'h0, exp_rgb(4'h0)});
        end
        chk("R7 glyph", {25'h0, disp_glyph}, {25'h0, c[6:0]});
        chk("R7 bold", {31'h0, disp_bold}, {31'h0, c[7]});
        chk("R8 fg", {8'h0, disp_fg}, {8'h0, exp_rgb(c[11:8])});
        chk("R8 bg", {8'h0, disp_bg}, {8'h0, exp_rgb(c[15:12])});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCELL; i++) m_cell[i] = '0;
        for (int i = 0; i < 48; i++) m_pal[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 ready idle", {31'h0, bus_ready}, 32'h1);
        chk("R1 irq idle", {31'h0, vsync_irq}, 32'h0);
        bus_rd(0, d);    chk("R1 cell zero", d, 32'h0);
        bus_rd(999, d);  chk("R1 last cell zero", d, 32'h0);
        bus_rd(1011, d); chk("R1 palette zero", d, 32'h0);
        disp_chk(0, 0);

        // R2: directed, full and partial writes
        bus_wr(0, 32'hA5C3_1F41, 4'hF);
        bus_rd(0, d); chk("R2 full word", d, exp_word(0));
        bus_wr(0, 32'h7777_8888, 4'b0110);
        bus_rd(0, d); chk("R2 partial bytes", d, 32'hA577_8841);
        // last cell: row 24 col 79 is cell 1999, high half of word 999
        bus_wr(999, 32'hE2B5_0000, 4'b1100);
        // R3: last palette byte, blue of entry 15, offset 0xFCF
        bus_wr(1011, 32'h5A00_0000, 4'b1000);
        bus_rd(1011, d); chk("R3 entry15 blue", d, 32'h5A00_0000);

        // R4: writes above the sync word are ignored, reads zero
        bus_wr(1013, 32'hFFFF_FFFF, 4'hF);
        bus_rd(1013, d); chk("R4 unmapped read", d, 32'h0);
        bus_rd(1023, d); chk("R4 top word read", d, 32'h0);

        // random writes across all regions except the sync word
        for (int n = 0; n < 1500; n++) begin
            int w;
            if ($urandom_range(0, 9) == 0) w = 1013 + $urandom_range(0, 10);
            else w = $urandom_range(0, 1011);
            bus_wr(w, $urandom, 4'($urandom));
        end

        // full readback (R2 cells, R3 palette, R4 unmapped incl. sync word)
        for (int w = 0; w < 1024; w++) begin
            bus_rd(w, d);
            if (w < 1000) chk("R2 readback", d, exp_word(w));
            else if (w < 1012) chk("R3 readback", d, exp_word(w));
            else chk("R4 readback", d, 32'h0);
        end

        // display lookups: corners, random, offscreen
        disp_chk(0, 0);
        disp_chk(79, 24);
        disp_chk(79, 0);
        for (int n = 0; n < 200; n++) disp_chk($urandom_range(0, 79), $urandom_range(0, 24));
        disp_chk(80, 3);
        disp_chk(5, 25);
        disp_chk(127, 31);
        for (int n = 0; n < 20; n++) disp_chk($urandom_range(80, 127), $urandom_range(0, 31));

        // R5 / R6: sync wait
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = 10'd1012; bus_wdata = '0; bus_be = 4'hF;
        for (int n = 0; n < 6; n++) begin
            #2 chk("R5 stalled", {31'h0, bus_ready}, 32'h0);
            @(negedge clk);
        end
        vsync_in = 1'b1;
        #2 chk("R5 released on sync", {31'h0, bus_ready}, 32'h1);
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
        @(negedge clk);
        vsync_in = 1'b0;
        chk("R6 irq pulse", {31'h0, vsync_irq}, 32'h1);
        @(negedge clk);
        chk("R6 irq single", {31'h0, vsync_irq}, 32'h0);
        // sync already present when the request arrives: no wait
        @(negedge clk);
        vsync_in = 1'b1; bus_valid = 1'b1; bus_write = 1'b1;
        #2 chk("R5 same-cycle sync", {31'h0, bus_ready}, 32'h1);
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
        @(negedge clk);
        vsync_in = 1'b0;
        chk("R6 irq again", {31'h0, vsync_irq}, 32'h1);
        // sync write left storage untouched
        bus_rd(1011, d); chk("R4 sync write no effect", d, exp_word(1011));
        bus_rd(0, d);    chk("R4 sync write no effect cell", d, exp_word(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule